// File: doc/BRIEF.md
# Double-Buffered DAC Code Register Front End

This block is the digital front end of a 12-bit voltage-output converter fed from a parallel bus. It keeps two code stages. The first is an input stage, loaded from the bus under chip select and write. The second is a converter stage, whose contents are the code that drives the analog ladder. A load strobe moves the input stage into the converter stage. A clear strobe zeroes the converter stage. Every control is active low, and each stage acts as a level-sensitive latch. While its controls are asserted a stage passes data straight through. When they release, it keeps the last value it passed.

The block lives in one system clock domain. The control pins and the data bus go through a two-stage synchronizer of equal depth, so data stays aligned with the controls that qualify it. The latch behaviour is then rebuilt at clock rate from the sampled levels. The block also watches for one timing hazard. If the load strobe overlaps a write, it must stay asserted for a minimum number of cycles after the write ends. A short hold is reported on a one-cycle flag.

Top module: `dac_dbuf_front`

## Requirements
- R1: While chip select, write and load are all low and clear is high, `code_o` follows `data_i`. A change on the pins appears on `code_o` no later than the fourth clock edge after it.
- R2: While chip select or write is high, the input stage keeps its value. Bus data presented then never reaches `code_o` on a later load.
- R3: A write ends when the first of chip select or write returns high. The input stage keeps the bus value sampled in the last cycle before that end, even if the bus changes in the same cycle.
- R4: The converter stage follows the input stage while load is low. It keeps its value while load is high, whatever writes take place.
- R5: While clear is low, `code_o` is zero, whatever the other controls are doing.
- R6: With both stages transparent, clear is only a momentary override. When clear returns high, `code_o` again follows `data_i`.
- R7: With both stages holding, a clear pulse leaves `code_o` at zero after clear returns high. The input stage is unaffected, and a later load restores its contents.
- R8: Load may be low during a write. If it then stays low for fewer than `HOLD_CYC` sampled cycles from the write's end (default 4), counting the end cycle, `hold_viol_o` pulses high for exactly one cycle. This also applies when load is already high at the write's end.
- R9: `hold_viol_o` stays low in two cases: load overlaps a write and is held for at least `HOLD_CYC` cycles, or load never overlaps a write.
- R10: Reset clears both stages to zero, so `code_o` is zero after reset and stays zero on a load with no prior write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously |
| data_i | input | DATA_W | Parallel code bus |
| cs_n_i | input | 1 | Chip select, active low |
| wr_n_i | input | 1 | Write strobe, active low |
| ldac_n_i | input | 1 | Load converter stage, active low |
| clr_n_i | input | 1 | Clear converter stage, active low |
| code_o | output | DATA_W | Converter stage code |
| hold_viol_o | output | 1 | One-cycle pulse on a load-hold violation |

## Verification
On every cycle, the assertions check how the synchronized controls relate to the stage contents. A write path that is closed keeps the input stage still, and a closed load path keeps the code still. A clear forces zero, and with every path open the code follows the bus. The violation flag is a single-cycle pulse seen only after load was high.

Other behaviour only shows across a sequence of pin activity, so only the bench scenarios can show it. This covers which bus value is captured when chip select rises ahead of write. It covers whether a clear persists or releases depending on the latch state. It also covers the exact hold count at which the violation flag starts or stops firing.

// File: rtl/dac_fe_pkg.sv
package dac_fe_pkg;
  typedef struct packed {
    logic cs_n;
    logic wr_n;
    logic ld_n;
    logic clr_n;
  } ctl_t;
endpackage

// File: rtl/dac_fe_sync.sv
module dac_fe_sync
  import dac_fe_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] data_i,
  input  ctl_t              ctl_i,
  output logic [DATA_W-1:0] data_o,
  output ctl_t              ctl_o
);
  ctl_t              cpipe [STAGES];
  logic [DATA_W-1:0] dpipe [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cpipe[0] <= '1;
          dpipe[0] <= '0;
        end else begin
          cpipe[0] <= ctl_i;
          dpipe[0] <= data_i;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cpipe[g] <= '1;
          dpipe[g] <= '0;
        end else begin
          cpipe[g] <= cpipe[g-1];
          dpipe[g] <= dpipe[g-1];
        end
      end
    end
  end

  assign ctl_o  = cpipe[STAGES-1];
  assign data_o = dpipe[STAGES-1];
endmodule

// File: rtl/dac_fe_latches.sv
module dac_fe_latches
  import dac_fe_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] data_s,
  input  ctl_t              ctl_s,
  output logic [DATA_W-1:0] in_q,
  output logic [DATA_W-1:0] dac_q
);
  logic              in_en;
  logic              dac_en;
  logic [DATA_W-1:0] in_nx;
  logic [DATA_W-1:0] dac_nx;

  always_comb begin
    in_en  = ~ctl_s.cs_n & ~ctl_s.wr_n;
    in_nx  = in_en ? data_s : in_q;
    dac_en = ~ctl_s.clr_n | ~ctl_s.ld_n;
    dac_nx = ~ctl_s.clr_n ? '0 : in_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q  <= '0;
      dac_q <= '0;
    end else begin
      if (in_en)  in_q  <= in_nx;
      if (dac_en) dac_q <= dac_nx;
    end
  end
endmodule

// File: rtl/dac_fe_holdchk.sv
module dac_fe_holdchk
  import dac_fe_pkg::*;
#(
  parameter int HOLD_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  ctl_t ctl_s,
  output logic viol_o
);
  localparam int CW = $clog2(HOLD_CYC + 1);

  logic          en_d, ovl_q, armed_q;
  logic [CW-1:0] cnt_q;
  logic          in_en, end_w;
  logic          ovl_nx, armed_nx, viol_nx;
  logic [CW-1:0] cnt_nx;

  always_comb begin
    in_en    = ~ctl_s.cs_n & ~ctl_s.wr_n;
    end_w    = en_d & ~in_en;
    ovl_nx   = ovl_q | (in_en & ~ctl_s.ld_n);
    armed_nx = armed_q;
    cnt_nx   = cnt_q;
    viol_nx  = 1'b0;
    if (end_w) begin
      ovl_nx = 1'b0;
      if (ovl_q) begin
        if (ctl_s.ld_n) begin
          viol_nx  = 1'b1;
          armed_nx = 1'b0;
        end else begin
          armed_nx = (HOLD_CYC > 1);
          cnt_nx   = CW'(1);
        end
      end
    end else if (armed_q) begin
      if (ctl_s.ld_n) begin
        viol_nx  = 1'b1;
        armed_nx = 1'b0;
      end else begin
        cnt_nx = cnt_q + 1'b1;
        if (cnt_nx >= CW'(HOLD_CYC)) armed_nx = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_d    <= 1'b0;
      ovl_q   <= 1'b0;
      armed_q <= 1'b0;
      cnt_q   <= '0;
      viol_o  <= 1'b0;
    end else begin
      en_d    <= in_en;
      ovl_q   <= ovl_nx;
      armed_q <= armed_nx;
      cnt_q   <= cnt_nx;
      viol_o  <= viol_nx;
    end
  end
endmodule

// File: rtl/dac_dbuf_front.sv
module dac_dbuf_front
  import dac_fe_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CYC    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] data_i,
  input  logic              cs_n_i,
  input  logic              wr_n_i,
  input  logic              ldac_n_i,
  input  logic              clr_n_i,
  output logic [DATA_W-1:0] code_o,
  output logic              hold_viol_o
);
  logic [1:0]        rst_pipe;
  logic              rst_q;
  ctl_t              ctl_raw, ctl_s;
  logic [DATA_W-1:0] data_s;
  logic [DATA_W-1:0] in_q;
  logic              cs_s, wr_s, ld_s, clr_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q = rst_pipe[1];

  assign ctl_raw = '{cs_n: cs_n_i, wr_n: wr_n_i, ld_n: ldac_n_i, clr_n: clr_n_i};
  assign cs_s  = ctl_s.cs_n;
  assign wr_s  = ctl_s.wr_n;
  assign ld_s  = ctl_s.ld_n;
  assign clr_s = ctl_s.clr_n;

  dac_fe_sync #(.DATA_W(DATA_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_q), .data_i(data_i), .ctl_i(ctl_raw),
    .data_o(data_s), .ctl_o(ctl_s)
  );

  dac_fe_latches #(.DATA_W(DATA_W)) u_lat (
    .clk(clk), .rst_n(rst_q), .data_s(data_s), .ctl_s(ctl_s),
    .in_q(in_q), .dac_q(code_o)
  );

  dac_fe_holdchk #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk(clk), .rst_n(rst_q), .ctl_s(ctl_s), .viol_o(hold_viol_o)
  );
endmodule

// File: rtl/dac_fe_checker.sv
module dac_fe_checker #(
  parameter int DATA_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_s,
  input logic              wr_s,
  input logic              ld_s,
  input logic              clr_s,
  input logic [DATA_W-1:0] data_s,
  input logic [DATA_W-1:0] in_q,
  input logic [DATA_W-1:0] code,
  input logic              viol
);
  p_flow_through_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_s && !wr_s && !ld_s && clr_s) |=> (code == $past(data_s)));

  p_input_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_s || wr_s) |=> $stable(in_q));

  p_dac_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_s && clr_s) |=> $stable(code));

  p_clear_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_s |=> (code == '0));

  p_viol_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    viol |=> !viol);

  p_viol_after_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    viol |-> $past(ld_s));
endmodule

bind dac_dbuf_front dac_fe_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_q), .cs_s(cs_s), .wr_s(wr_s), .ld_s(ld_s),
  .clr_s(clr_s), .data_s(data_s), .in_q(in_q), .code(code_o),
  .viol(hold_viol_o)
);

// File: tb/dac_dbuf_front_tb.sv
module dac_dbuf_front_tb;
  localparam int W = 12;
  localparam int HOLD = 4;
  localparam int SETTLE = 4;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] data;
  logic         cs_n, wr_n, ld_n, clr_n;
  logic [W-1:0] code;
  logic         viol;
  int           checks = 0;
  int           fails = 0;
  int           viol_cnt = 0;

  always #10 clk = ~clk;

  dac_dbuf_front #(.DATA_W(W), .SYNC_STAGES(2), .HOLD_CYC(HOLD)) u_dut (
    .clk(clk), .rst_n(rst_n), .data_i(data), .cs_n_i(cs_n), .wr_n_i(wr_n),
    .ldac_n_i(ld_n), .clr_n_i(clr_n), .code_o(code), .hold_viol_o(viol)
  );

  always @(negedge clk) if (viol) viol_cnt++;

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pins(input logic c, input logic w, input logic l, input logic k);
    cs_n = c; wr_n = w; ld_n = l; clr_n = k;
  endtask

  task automatic write_word(input logic [W-1:0] v);
    data = v; pins(1'b0, 1'b0, ld_n, clr_n); cyc(3);
    wr_n = 1'b1; cyc(2); cs_n = 1'b1; cyc(2);
  endtask

  task automatic load_pulse();
    ld_n = 1'b0; cyc(3); ld_n = 1'b1; cyc(SETTLE);
  endtask

  task automatic t_reset();
    chk("R10 code after reset", code, 0);
    load_pulse();
    chk("R10 input stage zero after reset", code, 0);
  endtask

  task automatic t_flow();
    int v0 = viol_cnt;
    pins(1'b0, 1'b0, 1'b0, 1'b1); data = 12'hA5C; cyc(SETTLE);
    chk("R1 follows bus", code, 12'hA5C);
    data = 12'h123; cyc(SETTLE);
    chk("R1 follows new bus value", code, 12'h123);
    wr_n = 1'b1; cyc(6); ld_n = 1'b1; cs_n = 1'b1; cyc(SETTLE);
    chk("R9 long hold no flag", viol_cnt - v0, 0);
    chk("R4 holds after load rises", code, 12'h123);
  endtask

  task automatic t_capture();
    pins(1'b0, 1'b0, 1'b1, 1'b1); data = 12'h3C1; cyc(3);
    cs_n = 1'b1; data = 12'hFFF; cyc(2); wr_n = 1'b1; cyc(2);
    load_pulse();
    chk("R3 capture before chip select rise", code, 12'h3C1);
    data = 12'h777; pins(1'b1, 1'b0, 1'b1, 1'b1); cyc(4);
    pins(1'b0, 1'b1, 1'b1, 1'b1); data = 12'h888; cyc(4);
    pins(1'b1, 1'b1, 1'b1, 1'b1);
    load_pulse();
    chk("R2 bus ignored with one strobe high", code, 12'h3C1);
  endtask

  task automatic t_dac_hold();
    write_word(12'h0F0); cyc(SETTLE);
    chk("R4 write does not reach code without load", code, 12'h3C1);
    load_pulse();
    chk("R4 load moves input to code", code, 12'h0F0);
    write_word(12'hABC); cyc(SETTLE);
    chk("R4 code holds across later write", code, 12'h0F0);
  endtask

  task automatic t_clear_hold();
    clr_n = 1'b0; cyc(SETTLE);
    chk("R5 clear forces zero", code, 0);
    clr_n = 1'b1; cyc(SETTLE);
    chk("R7 zero persists after clear", code, 0);
    load_pulse();
    chk("R7 input stage kept through clear", code, 12'hABC);
  endtask

  task automatic t_clear_override();
    pins(1'b0, 1'b0, 1'b0, 1'b1); data = 12'h555; cyc(SETTLE);
    chk("R1 transparent before override", code, 12'h555);
    clr_n = 1'b0; cyc(SETTLE);
    chk("R5 clear wins with load low", code, 0);
    data = 12'h666; cyc(SETTLE);
    chk("R6 override holds during clear", code, 0);
    clr_n = 1'b1; cyc(SETTLE);
    chk("R6 follows bus after clear release", code, 12'h666);
    wr_n = 1'b1; cyc(6); ld_n = 1'b1; cs_n = 1'b1; cyc(SETTLE);
  endtask

  task automatic t_viol();
    int v0;
    v0 = viol_cnt;
    pins(1'b0, 1'b0, 1'b0, 1'b1); data = 12'h111; cyc(3);
    wr_n = 1'b1; cyc(HOLD - 1); ld_n = 1'b1; cs_n = 1'b1; cyc(SETTLE);
    chk("R8 hold one short flags once", viol_cnt - v0, 1);
    v0 = viol_cnt;
    pins(1'b0, 1'b0, 1'b0, 1'b1); cyc(3);
    wr_n = 1'b1; cyc(HOLD); ld_n = 1'b1; cs_n = 1'b1; cyc(SETTLE);
    chk("R9 hold exactly limit no flag", viol_cnt - v0, 0);
    v0 = viol_cnt;
    pins(1'b0, 1'b0, 1'b0, 1'b1); cyc(3);
    ld_n = 1'b1; cyc(2); wr_n = 1'b1; cyc(2); cs_n = 1'b1; cyc(SETTLE);
    chk("R8 load released before write end flags", viol_cnt - v0, 1);
    v0 = viol_cnt;
    write_word(12'h222);
    ld_n = 1'b0; cyc(1); ld_n = 1'b1; cyc(SETTLE);
    chk("R9 no overlap no flag", viol_cnt - v0, 0);
  endtask

  initial begin
    rst_n = 1'b0; data = '0; pins(1'b1, 1'b1, 1'b1, 1'b1);
    cyc(4); rst_n = 1'b1; cyc(SETTLE);
    t_reset();
    t_flow();
    t_capture();
    t_dac_hold();
    t_clear_hold();
    t_clear_override();
    t_viol();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(20 * 100000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule